// File: doc/BRIEF.md
# Network Controller Interrupt and Power-Down Register Block

This block is the register front end that collects event pulses from a network controller's transmit and receive datapaths and turns them into one level-sensitive interrupt request for the CPU. Each event pulse sets a sticky bit in a status word. Software reads that word to find the cause of an interrupt. It uses a mask word to choose which causes raise the request. It removes causes by writing ones to a clear word and can raise causes itself by writing ones to a set word. One status bit, the software bit, has no hardware source. It exists so that software can test the interrupt path.

A power-down control bit shuts off register access. While that bit is 1, every access except one to the power-down register completes with an error response and changes nothing. Software therefore leaves power-down by writing 0 to that register. Hardware events still set status while access is blocked.

Accesses use a single-cycle request port. Each request gets exactly one response on the next cycle, carrying an error flag and read data. Register offsets are byte addresses: status 0x00 (read-only), mask 0x04, clear 0x08, set 0x0C, power-down 0x10.

Top module: `nic_irq_regs`

## Requirements
- R1: Every cycle with `req_valid_i` high is answered by exactly one cycle with `rsp_valid_o` high, on the following cycle. No response appears without a request.
- R2: A read of offset 0x00 returns the status word in bits 10:0 and zeros above. A write to offset 0x00 returns an error and leaves the status unchanged.
- R3: A 1 on `hw_evt_i[i]` sets status bit i (i = 0..9) at the next clock edge, and the bit stays set afterwards. Bits 0 to 6 are the receive errors (overrun, alignment, range, length, symbol, CRC, no descriptor), bit 7 is receive done, bit 8 is transmit done and bit 9 is transmit error. No input value clears a bit.
- R4: A write to offset 0x0C sets each status bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: A write to offset 0x08 clears each status bit whose write-data bit is 1. Reads of offsets 0x08 and 0x0C return zero.
- R6: When a hardware event and a clear write target the same bit in the same cycle, the bit ends up set.
- R7: Status bit 10 (software bit) is set only by a set write, never by `hw_evt_i`.
- R8: Offset 0x04 is a read/write mask over status bits 10:0. `irq_o` equals the OR of (status AND mask) as it stood one clock earlier.
- R9: Bit 0 of offset 0x10 is the power-down bit. While it is 1, any access to another offset returns an error and has no effect. Accesses to 0x10 still work.
- R10: An offset that is not one of the five listed, or that is not word aligned, returns an error with no effect. An error response always carries zero read data.
- R11: After reset the status, the mask and the power-down bit are zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hw_evt_i | input | 10 | One-cycle event pulses from the datapaths, one per status bit 0..9 |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_err_o | output | 1 | Error response |
| rsp_rdata_o | output | 32 | Read data, zero on writes and errors |
| irq_o | output | 1 | Level interrupt request to the CPU |

## Verification
The bench drives a clear write and a hardware pulse onto the same bit in one cycle. A design in which the clear wins would lose that event and read back zero there. It pulses every hardware input at once and expects the software bit to stay low. A design that wires the software bit to a hardware line would show it set. Under power-down it attempts set, mask and clear writes and then reads the words back after wake-up. A design that only flags the error but still performs the write would show changed values. The bench also checks misaligned and unmapped offsets, writes to the read-only status word, and the one-cycle lag of the interrupt behind the mask and status.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

    localparam int unsigned NIC_DATA_W    = 32;
    localparam int unsigned NIC_ADDR_W    = 5;
    localparam int unsigned NIC_HW_EVENTS = 10;

    // Which word an access selects
    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_MASK,
        SEL_CLEAR,
        SEL_SET,
        SEL_PWRDN,
        SEL_NONE
    } reg_sel_e;

    // Write strobes that leave the decoder, already qualified
    typedef struct packed {
        logic mask;
        logic clear;
        logic set;
        logic pwrdn;
    } wr_strobe_t;

    // Byte offsets; a neighbour decodes these, so they are fixed
    localparam logic [7:0] OFF_STATUS = 8'h00;
    localparam logic [7:0] OFF_MASK   = 8'h04;
    localparam logic [7:0] OFF_CLEAR  = 8'h08;
    localparam logic [7:0] OFF_SET    = 8'h0C;
    localparam logic [7:0] OFF_PWRDN  = 8'h10;

    function automatic reg_sel_e offset_to_sel(input logic [7:0] off);
        reg_sel_e s;
        case (off)
            OFF_STATUS: s = SEL_STATUS;
            OFF_MASK:   s = SEL_MASK;
            OFF_CLEAR:  s = SEL_CLEAR;
            OFF_SET:    s = SEL_SET;
            OFF_PWRDN:  s = SEL_PWRDN;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nic_irq_decode.sv
module nic_irq_decode
    import nic_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = NIC_ADDR_W
) (
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              pwrdn_i,
    output reg_sel_e          sel_o,
    output wr_strobe_t        wr_o,
    output logic              err_o
);

    logic illegal;
    logic accept;

    always_comb begin
        sel_o   = offset_to_sel(8'(req_addr_i));
        illegal = (sel_o == SEL_NONE)
                || (req_write_i && sel_o == SEL_STATUS)
                || (pwrdn_i && sel_o != SEL_PWRDN);
        err_o   = req_valid_i && illegal;
        accept  = req_valid_i && !illegal && req_write_i;
        wr_o.mask  = accept && (sel_o == SEL_MASK);
        wr_o.clear = accept && (sel_o == SEL_CLEAR);
        wr_o.set   = accept && (sel_o == SEL_SET);
        wr_o.pwrdn = accept && (sel_o == SEL_PWRDN);
    end

    // At most one word is written per access
    always_comb begin
        if (req_valid_i) begin
            AST_ONE_WRITE_STROBE: assert ($countones(wr_o) <= 1); // R9
        end
    end

endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import nic_irq_pkg::*;
#(
    parameter int unsigned HW_EVENTS = NIC_HW_EVENTS,
    localparam int unsigned STAT_W   = HW_EVENTS + 1,
    localparam int unsigned SOFT_BIT = HW_EVENTS
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [HW_EVENTS-1:0] hw_evt_i,
    input  logic                 set_we_i,
    input  logic                 clr_we_i,
    input  logic                 mask_we_i,
    input  logic [STAT_W-1:0]    wdata_i,
    output logic [STAT_W-1:0]    stat_o,
    output logic [STAT_W-1:0]    mask_o,
    output logic                 irq_o
);

    logic [STAT_W-1:0] stat_q, stat_d;
    logic [STAT_W-1:0] mask_q;
    logic              irq_q;

    // Per bit: a hardware source only where one exists; set beats clear
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        logic hw_set;
        if (i < HW_EVENTS) begin : g_hw
            assign hw_set = hw_evt_i[i];
        end else begin : g_sw
            assign hw_set = 1'b0;
        end
        assign stat_d[i] = hw_set
                         | (set_we_i & wdata_i[i])
                         | (stat_q[i] & ~(clr_we_i & wdata_i[i]));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            if (mask_we_i) begin
                mask_q <= wdata_i;
            end
            irq_q <= |(stat_q & mask_q);
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign irq_o  = irq_q;

    AST_HW_EVENT_STICKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (|hw_evt_i) |=> ((stat_q[HW_EVENTS-1:0] & $past(hw_evt_i)) == $past(hw_evt_i))); // R6

    AST_SOFT_ONLY_BY_SW: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(stat_q[SOFT_BIT]) |-> $past(set_we_i && wdata_i[SOFT_BIT])); // R7

    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        ((~stat_q & $past(stat_q)) & ~($past(clr_we_i) ? $past(wdata_i) : '0)) == '0); // R3

    AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !mask_we_i |=> $stable(mask_q)); // R8

endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
    import nic_irq_pkg::*;
#(
    parameter int unsigned HW_EVENTS = NIC_HW_EVENTS,
    parameter int unsigned DATA_W    = NIC_DATA_W,
    parameter int unsigned ADDR_W    = NIC_ADDR_W
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [HW_EVENTS-1:0] hw_evt_i,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [DATA_W-1:0]    req_wdata_i,
    output logic                 rsp_valid_o,
    output logic                 rsp_err_o,
    output logic [DATA_W-1:0]    rsp_rdata_o,
    output logic                 irq_o
);

    localparam int unsigned STAT_W = HW_EVENTS + 1;

    reg_sel_e          sel;
    wr_strobe_t        wr;
    logic              err;
    logic              pwrdn_q;
    logic [STAT_W-1:0] stat;
    logic [STAT_W-1:0] mask;
    logic [DATA_W-1:0] rdata_d;
    logic              rsp_valid_q;
    logic              rsp_err_q;
    logic [DATA_W-1:0] rsp_rdata_q;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^req_wdata_i[DATA_W-1:STAT_W];

    nic_irq_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .pwrdn_i     (pwrdn_q),
        .sel_o       (sel),
        .wr_o        (wr),
        .err_o       (err)
    );

    nic_irq_status #(
        .HW_EVENTS (HW_EVENTS)
    ) u_status (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .hw_evt_i  (hw_evt_i),
        .set_we_i  (wr.set),
        .clr_we_i  (wr.clear),
        .mask_we_i (wr.mask),
        .wdata_i   (req_wdata_i[STAT_W-1:0]),
        .stat_o    (stat),
        .mask_o    (mask),
        .irq_o     (irq_o)
    );

    always_comb begin
        rdata_d = '0;
        if (req_valid_i && !req_write_i && !err) begin
            case (sel)
                SEL_STATUS: rdata_d = DATA_W'(stat);
                SEL_MASK:   rdata_d = DATA_W'(mask);
                SEL_PWRDN:  rdata_d = DATA_W'(pwrdn_q);
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pwrdn_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            if (wr.pwrdn) begin
                pwrdn_q <= req_wdata_i[0];
            end
            rsp_valid_q <= req_valid_i;
            rsp_err_q   <= err;
            rsp_rdata_q <= rdata_d;
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_err_o   = rsp_err_q;
    assign rsp_rdata_o = rsp_rdata_q;

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        req_valid_i |=> rsp_valid_o); // R1

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_i |=> !rsp_valid_o); // R1

    AST_PWRDN_BLOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && pwrdn_q && 8'(req_addr_i) != OFF_PWRDN) |=> rsp_err_o); // R9

    AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
        rsp_err_o |-> (rsp_rdata_o == '0)); // R10

endmodule

// File: tb/sim_nic_irq_regs.sv
module sim_nic_irq_regs;

    typedef struct {
        logic        err;
        logic [31:0] rdata;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  hw_evt = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, irq;
    logic [31:0] rsp_rdata;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t q[$];

    // Bench model of the block's architectural state
    logic [10:0] m_stat = '0;
    logic [10:0] m_mask = '0;
    logic        m_pd   = 1'b0;
    logic        exp_irq_d = 1'b0;

    always #10 clk = ~clk;

    nic_irq_regs u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .hw_evt_i    (hw_evt),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .rsp_valid_o (rsp_valid),
        .rsp_err_o   (rsp_err),
        .rsp_rdata_o (rsp_rdata),
        .irq_o       (irq)
    );

    task automatic access(input logic wr, input logic [4:0] addr,
                          input logic [31:0] wd, input logic [9:0] hw,
                          input string tag);
        logic legal;
        logic [31:0] rd;
        logic [10:0] setm, clrm;
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; hw_evt = hw;
        legal = (addr == 5'h00 || addr == 5'h04 || addr == 5'h08 || addr == 5'h0C || addr == 5'h10)
              && !(m_pd && addr != 5'h10) && !(wr && addr == 5'h00);
        rd = '0;
        if (legal && !wr) begin
            case (addr)
                5'h00:   rd = {21'b0, m_stat};
                5'h04:   rd = {21'b0, m_mask};
                5'h10:   rd = {31'b0, m_pd};
                default: rd = '0;
            endcase
        end
        e.err = !legal; e.rdata = rd; e.tag = tag;
        q.push_back(e);
        exp_irq_d = |(m_stat & m_mask);
        setm = (legal && wr && addr == 5'h0C) ? wd[10:0] : '0;
        clrm = (legal && wr && addr == 5'h08) ? wd[10:0] : '0;
        m_stat = (m_stat & ~clrm) | setm | {1'b0, hw};
        if (legal && wr && addr == 5'h04) m_mask = wd[10:0];
        if (legal && wr && addr == 5'h10) m_pd = wd[0];
    endtask

    task automatic idle(input logic [9:0] hw);
        @(negedge clk);
        req_valid = 1'b0; hw_evt = hw;
        exp_irq_d = |(m_stat & m_mask);
        m_stat = m_stat | {1'b0, hw};
    endtask

    // Monitor: compares responses and the interrupt 2 ns after each edge
    always @(posedge clk) begin
        logic e_irq;
        exp_t e;
        e_irq = exp_irq_d;
        #2;
        if (!rst) begin
            n_checks++;
            if (irq !== e_irq) begin
                n_fail++;
                $display("FAIL R8 irq: actual %0b expected %0b", irq, e_irq);
            end
            if (rsp_valid) begin
                if (q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R1 response without request: actual valid 1 expected 0");
                end else begin
                    e = q.pop_front();
                    n_checks++;
                    if (rsp_err !== e.err || rsp_rdata !== e.rdata) begin
                        n_fail++;
                        $display("FAIL %s: actual err %0b data %h expected err %0b data %h",
                                 e.tag, rsp_err, rsp_rdata, e.err, e.rdata);
                    end
                end
            end else if (q.size() != 0) begin
                n_checks++; n_fail++;
                void'(q.pop_front());
                $display("FAIL R1 missing response: actual valid 0 expected 1");
            end
        end
    end

    initial begin : watchdog
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset values; R5 clear/set words read zero
        access(0, 5'h00, 0, 0, "R11 status after reset");
        access(0, 5'h04, 0, 0, "R11 mask after reset");
        access(0, 5'h10, 0, 0, "R11 pwrdn after reset");
        access(0, 5'h08, 0, 0, "R5 clear reads zero");
        access(0, 5'h0C, 0, 0, "R5 set reads zero");
        // R3 hardware pulse sets and sticks
        idle(10'h008);
        idle(10'h000);
        access(0, 5'h00, 0, 0, "R3 event bit 3 sticky");
        // R8 mask and interrupt lag
        access(1, 5'h04, 32'h0000_0008, 0, "R8 mask write");
        access(0, 5'h04, 0, 0, "R8 mask readback");
        idle(0); idle(0);
        // R5 clear
        access(1, 5'h08, 32'h0000_0008, 0, "R5 clear bit 3");
        access(0, 5'h00, 0, 0, "R5 status after clear");
        // R4 and R7 software bit
        access(1, 5'h0C, 32'h0000_0400, 0, "R4 set soft bit");
        access(0, 5'h00, 0, 0, "R7 soft bit by set write");
        access(1, 5'h0C, 32'h0000_0000, 0, "R4 zero set write");
        access(0, 5'h00, 0, 0, "R4 zeros keep value");
        access(1, 5'h08, 32'h0000_07FF, 0, "R5 clear all");
        idle(10'h3FF);
        access(0, 5'h00, 0, 0, "R7 hw all ones leaves soft bit low");
        // R6 set wins over clear
        access(1, 5'h08, 32'h0000_07FF, 10'h020, "R6 clear with event");
        access(0, 5'h00, 0, 0, "R6 event survives clear");
        // R2 status read-only
        access(1, 5'h00, 32'h0000_0000, 0, "R2 status write errors");
        access(0, 5'h00, 0, 0, "R2 status unchanged");
        // R10 unmapped and misaligned
        access(0, 5'h14, 0, 0, "R10 unmapped read");
        access(1, 5'h1C, 32'hFFFF_FFFF, 0, "R10 unmapped write");
        access(1, 5'h06, 32'h0000_07FF, 0, "R10 misaligned write");
        access(0, 5'h04, 0, 0, "R10 mask unchanged");
        // R9 power-down
        access(1, 5'h04, 32'h0000_0020, 0, "R9 mask before pd");
        access(1, 5'h10, 32'h0000_0001, 0, "R9 enter pd");
        access(0, 5'h10, 0, 0, "R9 pd readback");
        access(0, 5'h00, 0, 0, "R9 status blocked");
        access(1, 5'h0C, 32'h0000_0400, 0, "R9 set blocked");
        access(1, 5'h08, 32'h0000_07FF, 10'h001, "R9 clear blocked");
        access(1, 5'h04, 32'h0000_0000, 0, "R9 mask write blocked");
        access(1, 5'h10, 32'h0000_0000, 0, "R9 leave pd");
        access(0, 5'h00, 0, 0, "R9 status after pd");
        access(0, 5'h04, 0, 0, "R9 mask after pd");
        access(1, 5'h04, 32'h0000_0000, 0, "R8 mask off");
        idle(0); idle(0); idle(0);
        n_checks++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 pending responses: actual %0d expected 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule